// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a stream of oscillator ticks, nominally 32768 per second, into a one-clock pulse once per second and a second strobe once per minute. Each oscillator tick arrives as a one-cycle enable on the system clock, and the block counts only those enables. A digital trim makes up for crystal error. It does so by changing the length of selected seconds, not by stretching every second a little.

The trim word is six bits wide. The low five bits give a magnitude N, and the top bit gives the direction. Trim follows a cycle of 64 minutes. In the first 2×N minutes of each cycle, the first second of the minute is changed. A positive setting shortens that second by 128 oscillator ticks, which speeds the clock up. A negative setting lengthens it by 256 ticks, which slows the clock down. The trim word is captured once per cycle, so any later change waits for the next cycle to begin. A stop input freezes the whole count chain where it is.

Top module: `cal_prescaler`

## Requirements
- R1: While rst_ni is low, sec_tick_o and min_tick_o are low. The first second after reset starts with zero ticks counted, at second 0 of minute 0 of a new trim cycle.
- R2: An untrimmed second lasts exactly OSC_HZ accepted ticks. A tick is accepted when osc_tick_i is high and stop_i is low. sec_tick_o goes high for one clock in the cycle after the edge that takes in the tick closing the second.
- R3: When cal_i[5] is 1 (speed up) and the magnitude N = cal_i[4:0] is non-zero, second 0 of each minute with index below 2×N lasts OSC_HZ−SHORTEN ticks.
- R4: When cal_i[5] is 0 (slow down) and N is non-zero, second 0 of each minute with index below 2×N lasts OSC_HZ+LENGTHEN ticks.
- R5: When N is 0, no second is changed, whatever the value of cal_i[5].
- R6: min_tick_o goes high together with the sec_tick_o that closes second SEC_PER_MIN−1, and at no other time.
- R7: cal_i is captured on the first accepted tick of each trim cycle. A change to it later in the cycle has no effect until the next cycle.
- R8: While stop_i is high, no tick is accepted, all counters hold, and both outputs stay low.
- R9: A clock cycle with osc_tick_i low does not move any count.
- R10: A trim cycle lasts CYCLE_MIN minutes. Minutes with index at or above 2×N are not changed, so a magnitude with 2×N ≥ CYCLE_MIN changes every minute of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle enable for each oscillator period |
| stop_i | input | 1 | High freezes the whole divider chain |
| cal_i | input | MAG_W+1 | Trim word: [MAG_W] is the direction (1 = speed up), [MAG_W-1:0] is the magnitude |
| sec_tick_o | output | 1 | One-clock pulse at the end of each second |
| min_tick_o | output | 1 | One-clock pulse at the end of each minute |

## Verification
The bench scales the block down to OSC_HZ=32, SHORTEN=4, LENGTHEN=8, SEC_PER_MIN=4 and CYCLE_MIN=8, so that one whole trim cycle takes about a thousand ticks. At this size, many complete cycles fit into one run: cycle wraps, recapture of the trim word, and magnitudes where 2×N is larger than the cycle are all exercised often. The directed runs measure the total tick count of whole cycles and compare it with the closed-form sum. A random phase, with gaps in the oscillator ticks, stop pulses and changes to the trim word, is then checked tick by tick against a bench model.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_FAST = 2'd1,
    TRIM_SLOW = 2'd2
  } trim_e;
endpackage

// File: rtl/cal_prescaler_div.sv
module cal_prescaler_div
  import cal_prescaler_pkg::*;
#(
  parameter int unsigned OSC_HZ   = 32768,
  parameter int unsigned SHORTEN  = 128,
  parameter int unsigned LENGTHEN = 256
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  trim_e trim_i,
  output logic  sec_end_o
);
  localparam int unsigned LONG_LEN = OSC_HZ + LENGTHEN;
  localparam int unsigned CNT_W    = $clog2(LONG_LEN + 1);

  logic [CNT_W-1:0] cnt_q, len;

  always_comb begin
    unique case (trim_i)
      TRIM_FAST: len = CNT_W'(OSC_HZ - SHORTEN);
      TRIM_SLOW: len = CNT_W'(LONG_LEN);
      default:   len = CNT_W'(OSC_HZ);
    endcase
  end

  assign sec_end_o = adv_i && (cnt_q == len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (sec_end_o) cnt_q <= '0;
    else if (adv_i)     cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LONG_LEN));
endmodule

// File: rtl/cal_prescaler_sched.sv
module cal_prescaler_sched
  import cal_prescaler_pkg::*;
#(
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned CYCLE_MIN   = 64,
  parameter int unsigned MAG_W       = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         sec_end_i,
  input  logic [MAG_W:0] cal_i,
  output trim_e        trim_o,
  output logic         min_end_o
);
  localparam int unsigned SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int unsigned MIN_W = (CYCLE_MIN > 1) ? $clog2(CYCLE_MIN) : 1;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic             fresh_q;
  logic [MAG_W:0]   cal_q, eff_cal;
  logic [MAG_W-1:0] mag;
  logic             last_sec, last_min, in_window;

  // before the capture tick the live word governs second 0
  assign eff_cal   = fresh_q ? cal_i : cal_q;
  assign mag       = eff_cal[MAG_W-1:0];
  assign last_sec  = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign last_min  = (min_q == MIN_W'(CYCLE_MIN - 1));
  assign in_window = (mag != '0) && (32'(min_q) < (32'(mag) << 1));
  assign min_end_o = sec_end_i && last_sec;

  always_comb begin
    trim_o = TRIM_NONE;
    if (sec_q == '0 && in_window) trim_o = eff_cal[MAG_W] ? TRIM_FAST : TRIM_SLOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      min_q   <= '0;
      fresh_q <= 1'b1;
      cal_q   <= '0;
    end else if (adv_i) begin
      if (fresh_q) begin
        cal_q   <= cal_i;
        fresh_q <= 1'b0;
      end
      if (sec_end_i) begin
        if (last_sec) begin
          sec_q <= '0;
          if (last_min) begin
            min_q   <= '0;
            fresh_q <= 1'b1;
          end else begin
            min_q <= min_q + 1'b1;
          end
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end

  assert_cal_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |=> $stable(cal_q));
  assert_trim_first_sec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_o != TRIM_NONE) |-> (sec_q == '0));
  assert_sec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sec_q) < SEC_PER_MIN);
  assert_min_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(min_q) < CYCLE_MIN);
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_prescaler_pkg::*;
#(
  parameter int unsigned OSC_HZ      = 32768,
  parameter int unsigned SHORTEN     = 128,
  parameter int unsigned LENGTHEN    = 256,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned CYCLE_MIN   = 64,
  parameter int unsigned MAG_W       = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           osc_tick_i,
  input  logic           stop_i,
  input  logic [MAG_W:0] cal_i,
  output logic           sec_tick_o,
  output logic           min_tick_o
);
  logic  adv, sec_end, min_end;
  trim_e trim;

  assign adv = osc_tick_i && !stop_i;

  cal_prescaler_div #(
    .OSC_HZ(OSC_HZ), .SHORTEN(SHORTEN), .LENGTHEN(LENGTHEN)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .trim_i(trim), .sec_end_o(sec_end)
  );

  cal_prescaler_sched #(
    .SEC_PER_MIN(SEC_PER_MIN), .CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W)
  ) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .sec_end_i(sec_end),
    .cal_i(cal_i), .trim_o(trim), .min_end_o(min_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_tick_o <= 1'b0;
      min_tick_o <= 1'b0;
    end else begin
      sec_tick_o <= sec_end;
      min_tick_o <= min_end;
    end
  end

  assert_min_on_sec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> sec_tick_o);
  assert_quiet_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sec_tick_o && !min_tick_o);
  assert_quiet_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_tick_i |=> !sec_tick_o);
endmodule

// File: tb/tb_cal_prescaler.sv
module tb_cal_prescaler;
  localparam int OSC = 32, SH = 4, LG = 8, SPM = 4, CYC = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0, osc_tick_i = 1'b0, stop_i = 1'b0;
  logic [5:0] cal_i = '0;
  logic       sec_tick_o, min_tick_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  cal_prescaler #(
    .OSC_HZ(OSC), .SHORTEN(SH), .LENGTHEN(LG), .SEC_PER_MIN(SPM), .CYCLE_MIN(CYC), .MAG_W(5)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .stop_i(stop_i),
    .cal_i(cal_i), .sec_tick_o(sec_tick_o), .min_tick_o(min_tick_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int sec, input int mn, input logic [5:0] cal);
    int mag = int'(cal[4:0]);
    if (sec == 0 && mag != 0 && mn < 2 * mag) return cal[5] ? OSC - SH : OSC + LG;
    return OSC;
  endfunction

  function automatic int cycle_total(input logic [5:0] cal);
    int n = 2 * int'(cal[4:0]);
    if (n > CYC) n = CYC;
    return CYC * SPM * OSC + (cal[5] ? -n * SH : n * LG);
  endfunction

  // one whole trim cycle; c1 replaces c0 after ten ticks
  task automatic run_cycle(input logic [5:0] c0, input logic [5:0] c1, input string tag,
                           input bit pause, input bit gaps);
    int n = 0, mins = 0, k = 0, guard = 0;
    bit on = 1'b1, bad_quiet = 1'b0;
    cal_i = c0; osc_tick_i = 1'b1; stop_i = 1'b0;
    while (mins < CYC && guard < 20000) begin
      @(negedge clk_i);
      guard++;
      if (on) n++;
      if (!on && sec_tick_o) bad_quiet = 1'b1;
      if (min_tick_o) mins++;
      k++;
      cal_i      = (k > 10) ? c1 : c0;
      stop_i     = pause && k >= 100 && k < 120;
      osc_tick_i = gaps ? (k % 3 != 0) : 1'b1;
      on         = osc_tick_i && !stop_i;
    end
    check(mins == CYC, {tag, " R10 minutes"}, mins, CYC);
    check(n == cycle_total(c0), {tag, " cycle ticks"}, n, cycle_total(c0));
    check(!bad_quiet, "R8 R9 quiet output", int'(bad_quiet), 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int m_cnt, m_sec, m_min, len, tick_seen;
    bit m_fresh, on, e_sec, e_min;
    logic [5:0] m_cal;
    string tag;
    void'($urandom(32'd4242));

    // R1 reset state
    cal_i = 6'h23;
    repeat (3) @(negedge clk_i);
    check(!sec_tick_o && !min_tick_o, "R1 outputs in reset", int'(sec_tick_o), 0);
    rst_ni = 1'b1;

    run_cycle(6'h23, 6'h23, "R3 +3", 1'b0, 1'b0);
    run_cycle(6'h02, 6'h3F, "R7 R4 R8 -2 then +31", 1'b1, 1'b0);
    run_cycle(6'h20, 6'h20, "R5 R9 +0 gaps", 1'b0, 1'b1);
    run_cycle(6'h00, 6'h00, "R5 R2 -0", 1'b0, 1'b0);
    run_cycle(6'h1F, 6'h1F, "R10 -31", 1'b0, 1'b0);
    run_cycle(6'h01, 6'h01, "R4 -1", 1'b0, 1'b0);
    run_cycle(6'h21, 6'h21, "R3 +1", 1'b0, 1'b1);

    // random phase against the bench model
    @(negedge clk_i);
    rst_ni = 1'b0; osc_tick_i = 1'b0; stop_i = 1'b0;
    @(negedge clk_i);
    check(!sec_tick_o && !min_tick_o, "R1 outputs after reset", int'(sec_tick_o), 0);
    rst_ni = 1'b1;
    m_cnt = 0; m_sec = 0; m_min = 0; m_fresh = 1'b1; m_cal = '0; tick_seen = 0;
    cal_i = 6'($urandom); osc_tick_i = 1'b1; on = 1'b1;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk_i);
      e_sec = 1'b0; e_min = 1'b0; len = OSC;
      if (on) begin
        if (m_fresh) begin m_cal = cal_i; m_fresh = 1'b0; end
        len   = exp_len(m_sec, m_min, m_cal);
        e_sec = (m_cnt == len - 1);
        e_min = e_sec && (m_sec == SPM - 1);
        if (e_sec) begin
          m_cnt = 0;
          m_sec++;
          if (m_sec == SPM) begin
            m_sec = 0;
            m_min++;
            if (m_min == CYC) begin m_min = 0; m_fresh = 1'b1; end
          end
        end else m_cnt++;
      end
      if (!on)           tag = "R8 R9 idle";
      else if (len < OSC) tag = "R3 short second";
      else if (len > OSC) tag = "R4 long second";
      else if (m_cal[4:0] == 0) tag = "R5 zero magnitude";
      else tag = "R2 R10 nominal second";
      if (e_sec || sec_tick_o) begin
        check(sec_tick_o == e_sec, tag, int'(sec_tick_o), int'(e_sec));
        tick_seen++;
      end
      if (e_min || min_tick_o)
        check(min_tick_o == e_min, "R6 minute strobe", int'(min_tick_o), int'(e_min));
      // inputs for the next edge
      osc_tick_i = ($urandom % 5) != 0;
      stop_i     = ($urandom % 20) == 0;
      if (($urandom % 300) == 0) cal_i = 6'($urandom);
      on = osc_tick_i && !stop_i;
    end
    check(tick_seen > 100, "R2 random seconds seen", tick_seen, 101);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule